// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is a slave on a two-wire serial bus. A host reaches a small register file through it. The block watches the already-synchronized clock and data lines and finds START and STOP conditions. It accepts a frame only when the seven address bits match a fixed six-bit prefix followed by the level of a strap pin. It then takes one command byte that selects a register.

A write frame carries one data byte after the command. A read is done in two parts. The host first sends the command in a write frame. It then sends a repeated START, or a STOP followed by a new START, with the read address. The slave then returns the selected register, MSB first.

There are three read/write registers: an output divisor, a control byte and a signed frequency-trim byte. There is also a two-byte read-only temperature word, which comes from outside the block. The pointer never advances on its own. The temperature command is the one exception: it yields two consecutive bytes, both taken from one snapshot of the temperature word.

The block drives the bus through an open-drain pull-down output. It does not stretch the clock.

Top module: `twi_regslave`

## Requirements
- R1: The slave acknowledges an address byte equal to `{6'b100010, addr_strap, rw}` by pulling SDA low during the ninth clock pulse. On any other address it leaves SDA released and ignores the bus until the next START; bytes written in such a frame change no register.
- R2: A START (SDA falls while SCL is high) restarts address reception from any state, including in the middle of a frame. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: A write frame `addr+W, 5Dh, d` stores d in `divisor_q`, and `addr+W, 66h, d` stores d in `trim_q`. The slave acknowledges the address, the command and the data byte.
- R4: A write to command 60h stores data bits 3, 2 and 0 in `ctrl_q` at the same bit positions. `ctrl_q` bit 1 and bits 7:4 are always 0.
- R5: A read after a command byte returns the selected register MSB first. There is no auto-increment: for commands 5Dh, 60h and 66h, every byte after the first reads FFh (SDA released).
- R6: Command 64h returns `temp_word[15:8]` as the first byte and `{temp_word[7:6], 6'b0}` as the second. A third or later byte reads FFh.
- R7: `temp_word` is captured when a read address is acknowledged. A change of `temp_word` during the read does not affect the bytes of that read; the next read returns the new value.
- R8: After a NACK from the master, the slave keeps SDA released until the next START. Writes to 64h or to an undefined command are acknowledged but change nothing. A read of an undefined command returns FFh.
- R9: After reset, `divisor_q`, `ctrl_q` and `trim_q` are 00h and SDA is released. The command pointer resets to 00h, an undefined command, so a read issued before any command returns FFh.
- R10: The slave changes its SDA drive only while SCL is low. SDA is never pulled low while SCL is high, except where the pull was already in place when SCL went high.
- R11: Only one data byte is accepted per write frame. Further data bytes are not acknowledged and do not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (bus level) |
| addr_strap | input | 1 | Lowest bit of the slave address |
| temp_word | input | 16 | Latest temperature conversion (signed, 0.25 °C LSB at bit 6) |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| divisor_q | output | 8 | Divided-output ratio register |
| ctrl_q | output | 8 | Control register (bit 3, bit 2, bit 0 used) |
| trim_q | output | 8 | Signed frequency-trim register |

## Verification
Some rules hold on every cycle, and the embedded assertions check them there. The slave stays silent in idle, and a STOP always releases the line. The pull-down only turns on while SCL is low. Each register changes only on the data-byte edge of a write frame that selected that register. The temperature snapshot holds still for the whole of a read.

Other behaviour shows only across whole frames, so the bench scenarios cover it. This includes the address match against the strap, and the acknowledge timing. It also includes the FFh returned for a byte past the first, and the masking of the temperature fraction. The bench also covers the snapshot semantics when the word changes mid-read, and the refusal of a second data byte.

// File: rtl/twi_regslave.sv
module twi_regslave #(
  parameter logic [5:0] ADDR_PREFIX = 6'b100010,
  parameter logic [7:0] CMD_DIV     = 8'h5D,
  parameter logic [7:0] CMD_CTRL    = 8'h60,
  parameter logic [7:0] CMD_TEMP    = 8'h64,
  parameter logic [7:0] CMD_TRIM    = 8'h66
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_strap,
  input  logic [15:0] temp_word,
  output logic        sda_pull,
  output logic [7:0]  divisor_q,
  output logic [7:0]  ctrl_q,
  output logic [7:0]  trim_q
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_CMD, S_CMD_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } state_t;

  state_t      state;
  logic        scl_q, sda_q, rw;
  logic [2:0]  bitcnt;
  logic [1:0]  rd_idx;
  logic [7:0]  shreg, ptr, tx_byte;
  logic [15:0] shadow;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire [7:0] rx_byte = {shreg[6:0], sda_i};
  wire addr_hit = (rx_byte[7:1] == {ADDR_PREFIX, addr_strap});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    tx_byte = 8'hFF;
    if (rd_idx == 2'd0) begin
      case (ptr)
        CMD_DIV:  tx_byte = divisor_q;
        CMD_CTRL: tx_byte = ctrl_q;
        CMD_TRIM: tx_byte = trim_q;
        CMD_TEMP: tx_byte = shadow[15:8];
        default:  tx_byte = 8'hFF;
      endcase
    end else if (rd_idx == 2'd1 && ptr == CMD_TEMP) begin
      tx_byte = {shadow[7:6], 6'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sda_pull  <= 1'b0;
      rw        <= 1'b0;
      bitcnt    <= 3'd0;
      rd_idx    <= 2'd0;
      shreg     <= 8'h00;
      ptr       <= 8'h00;
      shadow    <= 16'h0000;
      divisor_q <= 8'h00;
      ctrl_q    <= 8'h00;
      trim_q    <= 8'h00;
    end else if (start_c) begin
      state    <= S_ADDR;
      bitcnt   <= 3'd0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_CMD, S_WR: begin
          if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (state == S_ADDR) begin
                if (addr_hit) begin
                  state <= S_ADDR_ACK;
                  rw    <= rx_byte[0];
                  if (rx_byte[0]) begin
                    shadow <= temp_word;
                    rd_idx <= 2'd0;
                  end
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_CMD) begin
                ptr   <= rx_byte;
                state <= S_CMD_ACK;
              end else begin
                case (ptr)
                  CMD_DIV:  divisor_q <= rx_byte;
                  CMD_CTRL: ctrl_q    <= {4'b0, rx_byte[3:2], 1'b0, rx_byte[0]};
                  CMD_TRIM: trim_q    <= rx_byte;
                  default:  ;
                endcase
                state <= S_WR_ACK;
              end
            end
          end
        end
        S_ADDR_ACK, S_CMD_ACK, S_WR_ACK: begin
          if (scl_fall) begin
            if (!sda_pull) begin
              sda_pull <= 1'b1;
            end else if (state == S_ADDR_ACK && rw) begin
              state    <= S_RD;
              sda_pull <= ~tx_byte[7];
            end else begin
              sda_pull <= 1'b0;
              state    <= (state == S_ADDR_ACK) ? S_CMD :
                          (state == S_CMD_ACK)  ? S_WR  : S_IDLE;
            end
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= S_RD_ACK;
          end else if (scl_fall) begin
            sda_pull <= ~tx_byte[~bitcnt];
          end
        end
        S_RD_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
          end else if (scl_rise) begin
            if (!sda_i) begin
              state  <= S_RD;
              rd_idx <= (rd_idx == 2'd3) ? 2'd3 : rd_idx + 2'd1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_pull);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE && !sda_pull));

  p_pull_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_q);

  p_div_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor_q) |-> ($past(state) == S_WR && $past(ptr) == CMD_DIV));

  p_trim_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim_q) |-> ($past(state) == S_WR && $past(ptr) == CMD_TRIM));

  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ($past(state) == S_WR && $past(ptr) == CMD_CTRL));

  p_temp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RD || state == S_RD_ACK) &&
     ($past(state) == S_RD || $past(state) == S_RD_ACK)) |-> $stable(shadow));

endmodule

// File: tb/twi_regslave_bench.sv
module twi_regslave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [15:0] temp = 16'h0000;
  logic sda_pull;
  logic [7:0] div_o, ctrl_o, trim_o;
  wire sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_err = 0;
  logic last_ack;
  logic [7:0] rb [0:3];

  always #2 clk = ~clk;

  twi_regslave u_twi_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_strap(strap), .temp_word(temp), .sda_pull(sda_pull),
    .divisor_q(div_o), .ctrl_q(ctrl_o), .trim_q(trim_o)
  );

  // cmd, write data, expected read-back
  localparam logic [23:0] VEC [0:5] = '{
    {8'h5D, 8'hA5, 8'hA5}, {8'h66, 8'h80, 8'h80}, {8'h60, 8'hFF, 8'h0D},
    {8'h60, 8'h06, 8'h04}, {8'h66, 8'h7F, 8'h7F}, {8'h5D, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] addr(input logic rw);
    return {6'b100010, strap, rw};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; tick(); scl = 1'b1; tick(); sda_m = 1'b0; tick(); scl = 1'b0; tick();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(); scl = 1'b1; tick(); sda_m = 1'b1; tick();
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(); scl = 1'b1; tick(); scl = 1'b0; tick();
    end
    sda_m = 1'b1; tick(); scl = 1'b1; tick();
    last_ack = sda_bus;
    scl = 1'b0; tick();
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    logic v;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(); scl = 1'b1; tick();
      v = sda_bus; tick();
      check("R10 sda stable while scl high", {15'd0, sda_bus}, {15'd0, v});
      b[i] = sda_bus;
      scl = 1'b0;
    end
    tick(); sda_m = ~mack; tick(); scl = 1'b1; tick(); scl = 1'b0; tick(); sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] cmd, input logic [7:0] d);
    i2c_start(); send(addr(1'b0)); send(cmd); send(d); i2c_stop();
  endtask

  task automatic read_reg(input logic [7:0] cmd, input int n);
    i2c_start(); send(addr(1'b0)); send(cmd);
    i2c_start(); send(addr(1'b1));
    for (int i = 0; i < n; i++) recv(i < n - 1, rb[i]);
    i2c_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R9 reset divisor", {8'd0, div_o}, 16'h0000);
    check("R9 reset ctrl", {8'd0, ctrl_o}, 16'h0000);
    check("R9 reset trim", {8'd0, trim_o}, 16'h0000);
    check("R9 reset sda released", {15'd0, sda_pull}, 16'h0000);

    // R9: read before any command hits the undefined pointer
    i2c_start(); send(addr(1'b1));
    check("R1 address ack", {15'd0, last_ack}, 16'h0000);
    recv(1'b0, rb[0]); i2c_stop();
    check("R9 read without command", {8'd0, rb[0]}, 16'h00FF);

    // R3 R4 R5: table of writes and read-backs
    for (int k = 0; k < 6; k++) begin
      logic [7:0] c, d, e, p;
      {c, d, e} = VEC[k];
      write_reg(c, d);
      p = (c == 8'h5D) ? div_o : (c == 8'h60) ? ctrl_o : trim_o;
      check("R3/R4 register port", {8'd0, p}, {8'd0, e});
      read_reg(c, 1);
      check("R5 read back", {8'd0, rb[0]}, {8'd0, e});
    end

    // R5: no auto-increment
    write_reg(8'h5D, 8'h3C);
    read_reg(8'h5D, 2);
    check("R5 first byte", {8'd0, rb[0]}, 16'h003C);
    check("R5 second byte FF", {8'd0, rb[1]}, 16'h00FF);

    // R1: address mismatch (strap low, bus carries strap bit 1)
    i2c_start(); send({6'b100010, 1'b1, 1'b0});
    check("R1 mismatch not acked", {15'd0, last_ack}, 16'h0001);
    send(8'h5D); send(8'h77); i2c_stop();
    check("R1 mismatch no write", {8'd0, div_o}, 16'h003C);

    // R1: strap high moves the address
    strap = 1'b1;
    i2c_start(); send(addr(1'b0));
    check("R1 strap-high ack", {15'd0, last_ack}, 16'h0000);
    send(8'h5D); send(8'h42); i2c_stop();
    check("R1 strap-high write", {8'd0, div_o}, 16'h0042);

    // R6: temperature bytes and masking
    temp = 16'h19FF;
    read_reg(8'h64, 3);
    check("R6 temp msb", {8'd0, rb[0]}, 16'h0019);
    check("R6 temp lsb masked", {8'd0, rb[1]}, 16'h00C0);
    check("R6 third byte FF", {8'd0, rb[2]}, 16'h00FF);

    // R7: snapshot held across the read
    temp = 16'hEC40;
    i2c_start(); send(addr(1'b0)); send(8'h64); i2c_start(); send(addr(1'b1));
    recv(1'b1, rb[0]);
    temp = 16'h5580;
    recv(1'b0, rb[1]); i2c_stop();
    check("R7 msb from snapshot", {8'd0, rb[0]}, 16'h00EC);
    check("R7 lsb from snapshot", {8'd0, rb[1]}, 16'h0040);
    read_reg(8'h64, 2);
    check("R7 new snapshot", {rb[0], rb[1]}, 16'h5580);

    // R8: ignored writes and undefined command
    write_reg(8'h64, 8'h55);
    read_reg(8'h64, 1);
    check("R8 temp write ignored", {8'd0, rb[0]}, 16'h0055);
    write_reg(8'h01, 8'hAA);
    check("R8 undefined write div", {8'd0, div_o}, 16'h0042);
    check("R8 undefined write ctrl", {8'd0, ctrl_o}, 16'h0004);
    check("R8 undefined write trim", {8'd0, trim_o}, 16'h007F);
    read_reg(8'h01, 1);
    check("R8 undefined read", {8'd0, rb[0]}, 16'h00FF);

    // R8: released after NACK, even with more clocks
    i2c_start(); send(addr(1'b0)); send(8'h60); i2c_start(); send(addr(1'b1));
    recv(1'b0, rb[0]);
    check("R8 ctrl read", {8'd0, rb[0]}, 16'h0004);
    for (int i = 0; i < 3; i++) begin
      tick(); scl = 1'b1; tick();
      check("R8 released after NACK", {15'd0, sda_pull}, 16'h0000);
      scl = 1'b0; tick();
    end
    i2c_stop();

    // R11: second data byte refused
    i2c_start(); send(addr(1'b0)); send(8'h66); send(8'h12);
    check("R11 first data acked", {15'd0, last_ack}, 16'h0000);
    send(8'h34);
    check("R11 second data not acked", {15'd0, last_ack}, 16'h0001);
    i2c_stop();
    check("R11 trim keeps first", {8'd0, trim_o}, 16'h0012);

    // R2: STOP mid-frame, then fresh frames
    i2c_start(); send(addr(1'b0)); send(8'h5D); i2c_stop();
    tick();
    check("R2 stop releases", {15'd0, sda_pull}, 16'h0000);
    check("R2 stop no write", {8'd0, div_o}, 16'h0042);
    i2c_start(); send(addr(1'b0)); send(8'h5D);
    sda_m = 1'b1; tick(); scl = 1'b1; tick(); scl = 1'b0; tick();
    i2c_start(); send(addr(1'b0)); send(8'h5D); send(8'h99); i2c_stop();
    check("R2 restart mid-byte", {8'd0, div_o}, 16'h0099);

    finish_run();
  end
endmodule